// File: doc/BRIEF.md
# Flash Busy-Status Read Responder

This block sits on the device side of a byte-wide parallel flash model. A host issues program and erase commands as a series of write-enable pulses. It then polls the read bus to learn when the internal operation has finished. The block counts those pulses, captures the data bit and page addresses it needs, and runs a cycle counter that stands in for the embedded algorithm. While the operation runs, it replaces normal read data with two status bits.

The top data bit is a completion flag whose polarity depends on the operation. The next bit inverts on every read access. When the operation completes, the override is released on the next cycle and reads pass the array data through unchanged. All strobes are active low and are sampled on the block clock. Edges are found by comparing each strobe with its value one cycle earlier. The array contents come in on a separate input bus.

Top module: `flash_status_resp`

## Requirements
- R1: After reset the block is idle: `busy_o` and `done_o` are low, and a read (chip enable and output enable both low) returns `array_data_i`.
- R2: `op_i` is sampled on the first write-enable pulse of a sequence, with 0 or 3 meaning program, 1 meaning chip erase and 2 meaning page erase. A program sequence is 4 pulses and the erase sequences are 6 pulses. Each pulse counts at a rising edge of write enable while chip enable is low. `busy_o` rises in the clock after the final pulse's rising edge and stays low after one pulse fewer.
- R3: During a program operation, read data bit 7 is the inverse of bit 7 of the byte on `wdata_i` at the final pulse, at any address. While busy, bits 5 to 0 read 0.
- R4: While busy, read data bit 6 inverts on each read access, starting at 1 on the first access. A read access is a falling edge of output enable while chip enable is low, or a falling edge of chip enable while output enable is low.
- R5: During a chip erase, read data bit 7 is 0 at every address.
- R6: A page erase first enters a time-out window of `TIMEOUT_CYCLES` cycles. Each further write-enable pulse in the window adds the page it addresses and restarts the window. Status stays active through the window and the busy phase that follows, so `busy_o` stays high for `TIMEOUT_CYCLES` + `busy_cycles_i` cycles after the last pulse.
- R7: During a page erase, the page is address bits [15:13]. A read in a selected page returns bit 7 = 0, and a read in any other page returns bit 7 of `array_data_i` with the toggle bit still active.
- R8: The busy phase lasts `busy_cycles_i` cycles, with 0 treated as 1. `done_o` is high for exactly one cycle, the last busy cycle, and `busy_o` is low in the next cycle.
- R9: Once the operation completes, reads return `array_data_i` unchanged and bit 6 no longer toggles.
- R10: Write-enable pulses while in the busy phase are ignored: the duration, the polarity bit and the pulse count for the next command do not change.
- R11: Whenever chip enable or output enable is high, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address; top PAGE_BITS select the page |
| wdata_i | input | DATA_W | Data presented with write pulses |
| op_i | input | 2 | Operation type for the command being issued |
| busy_cycles_i | input | CNT_W | Length of the busy phase in cycles |
| array_data_i | input | DATA_W | True array contents at the addressed byte |
| rdata_o | output | DATA_W | Read bus |
| busy_o | output | 1 | Status override active (window or busy phase) |
| done_o | output | 1 | One-cycle completion event |

## Verification
The checker watches five things on every cycle: the read bus is zero when not selected, idle reads pass the array data through, the low bits are zero while busy, bit 6 inverts after each read edge, and `done_o` is a lone pulse that ends the busy state. Some behaviour needs a full command history, and only the bench scenarios can show it. This covers the pulse count at which each operation starts, the bit 7 polarity for each operation type, membership in the selected pages, the duration including window restarts, and the ignoring of pulses during the busy phase.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [1:0] {
    K_PROG = 2'd0,
    K_CHIP = 2'd1,
    K_PAGE = 2'd2
  } op_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_TMO  = 2'd1,
    S_BUSY = 2'd2
  } seq_state_e;

  function automatic op_kind_e decode_op(input logic [1:0] code);
    case (code)
      2'd1:    return K_CHIP;
      2'd2:    return K_PAGE;
      default: return K_PROG;
    endcase
  endfunction

endpackage

// File: rtl/fsr_strobe_edge.sv
module fsr_strobe_edge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strobe_ni,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);

  for (genvar i = 0; i < N; i++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= strobe_ni[i];
    end
    assign fall_o[i] = prev_q & ~strobe_ni[i];
    assign rise_o[i] = ~prev_q & strobe_ni[i];
  end

endmodule

// File: rtl/fsr_seq_ctrl.sv
module fsr_seq_ctrl
  import flash_status_pkg::*;
#(
  parameter int PAGE_BITS      = 3,
  parameter int CNT_W          = 16,
  parameter int TIMEOUT_CYCLES = 20,
  parameter int PROG_PULSES    = 4,
  parameter int ERASE_PULSES   = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_rise_i,
  input  logic [1:0]                 op_i,
  input  logic [PAGE_BITS-1:0]       page_i,
  input  logic                       wbit7_i,
  input  logic [CNT_W-1:0]           busy_cycles_i,
  output op_kind_e                   kind_o,
  output logic                       active_o,
  output logic                       done_o,
  output logic                       inv_bit7_o,
  output logic [(1<<PAGE_BITS)-1:0]  page_mask_o
);

  localparam int NUM_PAGES  = 1 << PAGE_BITS;
  localparam int MAX_PULSES = (PROG_PULSES > ERASE_PULSES) ? PROG_PULSES : ERASE_PULSES;
  localparam int PULSE_W    = $clog2(MAX_PULSES + 1);
  localparam int TMO_W      = $clog2(TIMEOUT_CYCLES + 1);

  seq_state_e             state_q;
  op_kind_e               kind_q, seq_kind;
  logic [PULSE_W-1:0]     pcnt_q, need;
  logic [CNT_W-1:0]       busy_q, busy_load;
  logic [TMO_W-1:0]       tmo_q;
  logic [NUM_PAGES-1:0]   mask_q, page_hot;
  logic                   bit7_q;
  logic                   last_pulse;

  always_comb begin
    seq_kind   = (pcnt_q == '0) ? decode_op(op_i) : kind_q;
    need       = (seq_kind == K_PROG) ? PULSE_W'(PROG_PULSES) : PULSE_W'(ERASE_PULSES);
    last_pulse = we_rise_i && (state_q == S_IDLE) && (pcnt_q + PULSE_W'(1) == need);
    page_hot   = NUM_PAGES'(1) << page_i;
    busy_load  = (busy_cycles_i == '0) ? CNT_W'(1) : busy_cycles_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_PROG;
      pcnt_q  <= '0;
      busy_q  <= '0;
      tmo_q   <= '0;
      mask_q  <= '0;
      bit7_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (we_rise_i) begin
            kind_q <= seq_kind;
            if (last_pulse) begin
              pcnt_q <= '0;
              bit7_q <= wbit7_i;
              if (seq_kind == K_PAGE) begin
                state_q <= S_TMO;
                tmo_q   <= TMO_W'(TIMEOUT_CYCLES);
                mask_q  <= page_hot;
              end else begin
                state_q <= S_BUSY;
                busy_q  <= busy_load;
              end
            end else begin
              pcnt_q <= pcnt_q + PULSE_W'(1);
            end
          end
        end
        S_TMO: begin
          if (we_rise_i) begin
            mask_q <= mask_q | page_hot;
            tmo_q  <= TMO_W'(TIMEOUT_CYCLES);
          end else if (tmo_q <= TMO_W'(1)) begin
            state_q <= S_BUSY;
            busy_q  <= busy_load;
          end else begin
            tmo_q <= tmo_q - TMO_W'(1);
          end
        end
        S_BUSY: begin
          // write pulses are not decoded here
          if (busy_q <= CNT_W'(1)) state_q <= S_IDLE;
          else                     busy_q  <= busy_q - CNT_W'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign kind_o      = kind_q;
  assign active_o    = (state_q != S_IDLE);
  assign done_o      = (state_q == S_BUSY) && (busy_q <= CNT_W'(1));
  assign inv_bit7_o  = ~bit7_q;
  assign page_mask_o = mask_q;

endmodule

// File: rtl/fsr_read_mux.sv
module fsr_read_mux
  import flash_status_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      read_edge_i,
  input  logic                      ce_ni,
  input  logic                      oe_ni,
  input  logic                      active_i,
  input  op_kind_e                  kind_i,
  input  logic                      inv_bit7_i,
  input  logic [PAGE_BITS-1:0]      page_i,
  input  logic [(1<<PAGE_BITS)-1:0] page_mask_i,
  input  logic [DATA_W-1:0]         array_data_i,
  output logic [DATA_W-1:0]         rdata_o
);

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic tog_q;
  logic poll_bit;
  logic page_hit;

  // toggle restarts at 0 for every operation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tog_q <= 1'b0;
    else if (!active_i)   tog_q <= 1'b0;
    else if (read_edge_i) tog_q <= ~tog_q;
  end

  assign page_hit = page_mask_i[page_i];

  always_comb begin
    case (kind_i)
      K_PROG:  poll_bit = inv_bit7_i;
      K_CHIP:  poll_bit = 1'b0;
      default: poll_bit = page_hit ? 1'b0 : array_data_i[POLL_BIT];
    endcase
  end

  always_comb begin
    rdata_o = '0;
    if (!ce_ni && !oe_ni) begin
      if (active_i) begin
        rdata_o[POLL_BIT] = poll_bit;
        rdata_o[TOG_BIT]  = tog_q;
      end else begin
        rdata_o = array_data_i;
      end
    end
  end

endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_status_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int PAGE_BITS      = 3,
  parameter int CNT_W          = 16,
  parameter int TIMEOUT_CYCLES = 20,
  parameter int PROG_PULSES    = 4,
  parameter int ERASE_PULSES   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        op_i,
  input  logic [CNT_W-1:0]  busy_cycles_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int NUM_PAGES = 1 << PAGE_BITS;
  localparam int STB_WE = 0;
  localparam int STB_OE = 1;
  localparam int STB_CE = 2;

  logic [2:0]           stb_fall, stb_rise;
  logic                 we_rise, read_edge;
  logic [PAGE_BITS-1:0] page;
  op_kind_e             kind;
  logic                 active, inv_bit7;
  logic [NUM_PAGES-1:0] page_mask;
  logic                 unused_bits;

  assign page        = addr_i[ADDR_W-1 -: PAGE_BITS];
  assign unused_bits = ^{addr_i[ADDR_W-PAGE_BITS-1:0], wdata_i[DATA_W-2:0]};

  fsr_strobe_edge #(.N(3)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_ni ({ce_ni, oe_ni, we_ni}),
    .fall_o    (stb_fall),
    .rise_o    (stb_rise)
  );

  assign we_rise   = stb_rise[STB_WE] & ~ce_ni;
  assign read_edge = (stb_fall[STB_OE] & ~ce_ni) | (stb_fall[STB_CE] & ~oe_ni);

  fsr_seq_ctrl #(
    .PAGE_BITS      (PAGE_BITS),
    .CNT_W          (CNT_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .PROG_PULSES    (PROG_PULSES),
    .ERASE_PULSES   (ERASE_PULSES)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_rise_i     (we_rise),
    .op_i          (op_i),
    .page_i        (page),
    .wbit7_i       (wdata_i[DATA_W-1]),
    .busy_cycles_i (busy_cycles_i),
    .kind_o        (kind),
    .active_o      (active),
    .done_o        (done_o),
    .inv_bit7_o    (inv_bit7),
    .page_mask_o   (page_mask)
  );

  fsr_read_mux #(
    .DATA_W    (DATA_W),
    .PAGE_BITS (PAGE_BITS)
  ) u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .read_edge_i  (read_edge),
    .ce_ni        (ce_ni),
    .oe_ni        (oe_ni),
    .active_i     (active),
    .kind_i       (kind),
    .inv_bit7_i   (inv_bit7),
    .page_i       (page),
    .page_mask_i  (page_mask),
    .array_data_i (array_data_i),
    .rdata_o      (rdata_o)
  );

  assign busy_o = active;

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              busy_o,
  input logic              done_o
);

  p_bus_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> (rdata_o == '0));

  p_idle_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !ce_ni && !oe_ni) |-> (rdata_o == array_data_i));

  p_low_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ce_ni && !oe_ni) |-> (rdata_o[DATA_W-3:0] == '0));

  p_toggle_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(oe_ni) && !ce_ni && busy_o) |=>
      (oe_ni || ce_ni || !busy_o || (rdata_o[DATA_W-2] != $past(rdata_o[DATA_W-2]))));

  p_done_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_done_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));

endmodule

bind flash_status_resp flash_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_status_resp_test.sv
module flash_status_resp_test;

  localparam int TMO = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, arr = '0;
  logic [1:0]  op = '0;
  logic [15:0] bcyc = 16'd1;
  logic [7:0]  rdata;
  logic        busy, done;

  int checks = 0, errors = 0;
  int cyc = 0, done_cnt = 0, done_cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n && done) begin done_cnt++; done_cyc = cyc; end

  flash_status_resp #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .wdata_i(wdata), .op_i(op), .busy_cycles_i(bcyc),
    .array_data_i(arr), .rdata_o(rdata), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_busy(int kind, logic d7, logic tg, logic inpg, logic [7:0] a);
    logic b7;
    if (kind == 0)      b7 = ~d7;
    else if (kind == 1) b7 = 1'b0;
    else                b7 = inpg ? 1'b0 : a[7];
    return {b7, tg, 6'b0};
  endfunction

  task automatic pulse(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_oe(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; arr = 8'($urandom); oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); v = rdata; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_ce(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; arr = 8'($urandom); ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); check("R11 quiet with chip enable high", int'(rdata), 0); ce_n = 1'b0;
    @(negedge clk);
    @(negedge clk); v = rdata; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_op(input int kind, input int b, input int nreads, input bit we_during);
    int          npul, start, total, d0;
    logic [7:0]  d, v;
    logic [2:0]  p1, p2, pr;
    logic [7:0]  mask;
    logic        tg;
    string       rq;
    rq   = (kind == 0) ? "R3" : (kind == 1) ? "R5" : "R7";
    npul = (kind == 0) ? 4 : 6;
    bcyc = 16'(b);
    op   = 2'(kind);
    for (int i = 0; i < npul - 1; i++) pulse(16'($urandom), 8'($urandom));
    check("R2 not busy one pulse short", int'(busy), 0);
    d  = 8'($urandom);
    p1 = 3'($urandom);
    op = 2'($urandom);  // ignored after the first pulse
    pulse({p1, 13'($urandom)}, d);
    check("R2 busy after final pulse", int'(busy), 1);
    mask = 8'(1) << p1;
    if (kind == 2) begin
      p2 = 3'($urandom);
      pulse({p2, 13'($urandom)}, 8'($urandom));
      mask = mask | (8'(1) << p2);
      total = TMO + b;
    end else begin
      total = b;
    end
    start = cyc;
    d0 = done_cnt;
    tg = 1'b0;
    for (int r = 0; r < nreads; r++) begin
      pr = (r % 2 == 0) ? p1 : 3'($urandom);
      if (kind == 2 && r == 1)
        for (int k = 0; k < 16 && mask[pr]; k++) pr = 3'($urandom);
      if (r % 2 == 0) read_oe({pr, 13'($urandom)}, v);
      else            read_ce({pr, 13'($urandom)}, v);
      tg = ~tg;
      check({rq, " R4 status read"}, int'(v), int'(exp_busy(kind, d[7], tg, mask[pr], arr)));
    end
    check("R11 quiet while busy", int'(rdata), 0);
    if (we_during) begin
      op = 2'd1;
      pulse(16'($urandom), ~d);
      read_oe(16'($urandom), v);
      tg = ~tg;
      check("R10 pulse in busy ignored", int'(v), int'(exp_busy(kind, d[7], tg, 1'b0, arr)));
    end
    for (int g = 0; g < 4000 && busy; g++) @(negedge clk);
    if (kind == 2) check("R6 window plus busy length", cyc - start, total);
    else           check("R8 busy length", cyc - start, total);
    check("R8 one done pulse", done_cnt - d0, 1);
    check("R8 done on last busy cycle", done_cyc, start + total - 1);
    read_oe(16'($urandom), v);
    check("R9 array after done", int'(v), int'(arr));
    read_ce(16'($urandom), v);
    check("R9 no toggle after done", int'(v), int'(arr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(busy), 0);
    check("R1 no done after reset", int'(done), 0);
    check("R11 quiet bus after reset", int'(rdata), 0);
    read_oe(16'h1234, v);
    check("R1 idle read passes array", int'(v), int'(arr));
    // directed corners
    run_op(0, 40, 4, 1'b1);
    run_op(1, 35, 3, 1'b1);
    run_op(2, 30, 4, 1'b0);
    run_op(0, 30, 1, 1'b0);
    // random mix
    for (int it = 0; it < 8; it++) begin
      int k;
      k = int'($urandom % 3);
      run_op(k, 30 + int'($urandom % 40), 1 + int'($urandom % 4),
             (k != 2) && ($urandom % 2 == 1));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule